// File: doc/BRIEF.md
# Command-Sequenced Virtual Register Bus Slave

This block answers a CPU on an 8-bit asynchronous bus of the 68000 style. It watches the upper address bits for a strobed access that falls inside an I/O window. When it sees one, it holds the data acknowledge back until the transfer has been served. Only the two lowest address bits pick a register, so the four registers repeat across the whole window. A configuration strap picks the window. With the strap low (minimal map), any address with bit 19 set is I/O. With the strap high (extended map), only the top 16 KB is I/O, which is the range where bits 19 down to 14 are all one.

Software uses a two-step protocol. First it writes a command code to the opcode register. It then moves one or more data bytes through the execute register. A byte index counts the data bytes moved under the current command. The commands reach three small internal functions:
- a transmit FIFO, which the surrounding logic drains through a pop port;
- a receive FIFO, which the surrounding logic fills through a push port;
- a four-byte scratch store.

Interrupt-acknowledge cycles are never treated as register accesses.

Top module: `vio_bus_slave`

## Requirements
- R1: With the strap high, an access is decoded as I/O exactly when address bits 19..14 are all one. The register is chosen by address bits 1..0 alone, so every mirror of an offset behaves the same (e.g. 0xFFFFD and 0xFC001 both reach the opcode register).
- R2: With the strap low, an access is decoded as I/O exactly when address bit 19 is one.
- R3: A strobed access outside the window never drives the data bus (output enable stays 0) and never asserts the active-low acknowledge.
- R4: While the interrupt-acknowledge input is high, a strobed access starts no register access: there is no acknowledge and no state change.
- R5: The acknowledge (active low) goes low after the second rising clock edge that follows the rising edge that first samples the strobe low. This happens only once the service step is complete. The acknowledge returns high in the same cycle that the strobe is negated.
- R6: Offset 01 is the opcode register. A write stores the code and resets the byte index to zero. A read returns the stored code.
- R7: Offsets 10 and 11 are reserved. They read 0xFF, and writes to them change nothing.
- R8: Under opcode 0x01, each write to the execute register (offset 00) pushes its byte into the 4-entry transmit FIFO. A push into a full FIFO is dropped. Bytes leave the FIFO in order.
- R9: Under opcode 0x81, a read of the execute register pops one byte from the receive FIFO. If the receive FIFO is empty, the read returns 0xFF.
- R10: Under opcode 0x02, execute writes fill the scratch store at the byte index. Under opcode 0x82, execute reads return the scratch store at the byte index. Each such transfer advances the index, which wraps modulo 4. An execute access in the other direction has no effect and reads 0xFF.
- R11: Under any other opcode, an execute read returns 0xFF and an execute write has no effect. The cycle is still acknowledged.
- R12: A receive push from the port and a CPU pop in the same clock cycle are both honoured, including when the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 20 | CPU address bus |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = CPU read, 0 = CPU write |
| iack | input | 1 | Interrupt-acknowledge cycle in progress |
| ext_map | input | 1 | Strap: 1 = extended 16 KB window, 0 = minimal window (bit 19) |
| din | input | 8 | Data from the CPU |
| dout | output | 8 | Data to the CPU |
| dout_en | output | 1 | Data bus drive enable |
| dtack_n | output | 1 | Data acknowledge, active low |
| tx_pop | input | 1 | Remove the head byte of the transmit FIFO |
| tx_data | output | 8 | Head byte of the transmit FIFO |
| tx_empty | output | 1 | Transmit FIFO is empty |
| rx_push | input | 1 | Write rx_byte into the receive FIFO |
| rx_byte | input | 8 | Received byte |
| rx_full | output | 1 | Receive FIFO is full |

## Verification
Two functions can land on the same clock edge:
- the receive FIFO being filled from its port, and
- a CPU execute read under opcode 0x81 draining that FIFO.

The bench provokes this by raising the push in the cycle whose closing edge performs the service step, once with two bytes queued and once with the FIFO full. It judges the result by the order of every byte read back afterwards, up to the final 0xFF that marks an empty FIFO. A lost push or a double pop shows up as a missing or repeated value.

// File: rtl/vio_pkg.sv
package vio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_HOLD = 2'd2,
        ST_ACK  = 2'd3
    } vio_state_e;

    typedef enum logic [1:0] {
        REG_DATA = 2'b00,
        REG_OPC  = 2'b01,
        REG_RSV0 = 2'b10,
        REG_RSV1 = 2'b11
    } vio_reg_e;

    typedef struct packed {
        vio_reg_e   reg_sel;
        logic       rd;
        logic [7:0] wdata;
    } vio_req_t;

    localparam logic [7:0] OP_TX_SEND  = 8'h01;
    localparam logic [7:0] OP_SCR_WR   = 8'h02;
    localparam logic [7:0] OP_RX_RECV  = 8'h81;
    localparam logic [7:0] OP_SCR_RD   = 8'h82;
    localparam logic [7:0] IDLE_BYTE   = 8'hFF;

    function automatic logic win_hit(input logic ext, input logic top_bit,
                                     input logic top_all_ones);
        return ext ? top_all_ones : top_bit;
    endfunction

endpackage

// File: rtl/vio_decode.sv
module vio_decode #(
    parameter int ADDR_W   = 20,
    parameter int EXT_BITS = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_map,
    output logic              io_sel,
    output logic [1:0]        reg_off
);
    import vio_pkg::*;

    localparam int TOP = ADDR_W - 1;

    logic top_ones;

    always_comb begin
        top_ones = &addr[TOP -: EXT_BITS];
        io_sel   = win_hit(ext_map, addr[TOP], top_ones);
        reg_off  = addr[1:0];
    end

endmodule

// File: rtl/vio_fifo.sv
module vio_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == CAP);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        rdata   = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= wdata;
                wp      <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (cnt == $past(cnt)));

    assert_push_pop_same_cycle_R12: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty) |=> $stable(cnt));

endmodule

// File: rtl/vio_engine.sv
module vio_engine #(
    parameter int SCR_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       io_sel,
    input  logic [1:0] reg_off,
    input  logic       ds_n,
    input  logic       rw,
    input  logic       iack,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       dout_en,
    output logic       dtack_n,
    output logic       tx_push,
    output logic [7:0] tx_wdata,
    input  logic       tx_full,
    output logic       rx_pop,
    input  logic [7:0] rx_rdata,
    input  logic       rx_empty
);
    import vio_pkg::*;

    localparam int IW = (SCR_DEPTH > 1) ? $clog2(SCR_DEPTH) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(SCR_DEPTH - 1);

    vio_state_e state;
    vio_req_t   req;
    logic [7:0] opcode;
    logic [7:0] rd_reg;
    logic [IW-1:0] idx;
    logic [7:0] scratch [SCR_DEPTH];

    logic       serving, on_data, scr_wr, scr_rd;
    logic [7:0] next_rd;

    always_comb begin
        serving  = (state == ST_EXEC);
        on_data  = (req.reg_sel == REG_DATA);
        tx_push  = serving && on_data && !req.rd && (opcode == OP_TX_SEND) && !tx_full;
        tx_wdata = req.wdata;
        rx_pop   = serving && on_data && req.rd && (opcode == OP_RX_RECV);
        scr_wr   = serving && on_data && !req.rd && (opcode == OP_SCR_WR);
        scr_rd   = serving && on_data && req.rd && (opcode == OP_SCR_RD);

        next_rd = IDLE_BYTE;
        case (req.reg_sel)
            REG_OPC:  next_rd = opcode;
            REG_DATA: begin
                if (opcode == OP_RX_RECV)     next_rd = rx_empty ? IDLE_BYTE : rx_rdata;
                else if (opcode == OP_SCR_RD) next_rd = scratch[idx];
            end
            default:  next_rd = IDLE_BYTE;
        endcase

        dout    = rd_reg;
        dout_en = (state == ST_ACK) && req.rd && !ds_n;
        dtack_n = !((state == ST_ACK) && !ds_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            req    <= '{reg_sel: REG_RSV1, rd: 1'b1, wdata: 8'h00};
            opcode <= 8'h00;
            rd_reg <= IDLE_BYTE;
            idx    <= '0;
            for (int i = 0; i < SCR_DEPTH; i++) scratch[i] <= 8'h00;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (io_sel && !ds_n && !iack) begin
                        req.reg_sel <= vio_reg_e'(reg_off);
                        req.rd      <= rw;
                        req.wdata   <= din;
                        state       <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    rd_reg <= next_rd;
                    if (req.reg_sel == REG_OPC && !req.rd) begin
                        opcode <= req.wdata;
                        idx    <= '0;
                    end
                    if (scr_wr) scratch[idx] <= req.wdata;
                    if (scr_wr || scr_rd) idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
                    state <= ST_HOLD;
                end
                ST_HOLD: state <= ST_ACK;
                ST_ACK:  if (ds_n) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_ack_after_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK) |-> ($past(state) == ST_HOLD || $past(state) == ST_ACK));

    assert_opcode_resets_index_R6: assert property (@(posedge clk) disable iff (rst)
        (serving && req.reg_sel == REG_OPC && !req.rd) |=>
            (idx == '0 && opcode == $past(req.wdata)));

    assert_reserved_no_effect_R7: assert property (@(posedge clk) disable iff (rst)
        (serving && req.reg_sel[1]) |=> ($stable(opcode) && $stable(idx)));

    assert_iack_no_start_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && iack) |=> (state == ST_IDLE));

endmodule

// File: rtl/vio_bus_slave.sv
module vio_bus_slave #(
    parameter int ADDR_W    = 20,
    parameter int EXT_BITS  = 6,
    parameter int FIFO_D    = 4,
    parameter int SCR_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ds_n,
    input  logic              rw,
    input  logic              iack,
    input  logic              ext_map,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              dtack_n,
    input  logic              tx_pop,
    output logic [7:0]        tx_data,
    output logic              tx_empty,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    output logic              rx_full
);
    logic       io_sel;
    logic [1:0] reg_off;
    logic       tx_push, tx_full, rx_pop, rx_empty;
    logic [7:0] tx_wdata, rx_rdata;

    vio_decode #(.ADDR_W(ADDR_W), .EXT_BITS(EXT_BITS)) u_dec (
        .addr(addr), .ext_map(ext_map), .io_sel(io_sel), .reg_off(reg_off)
    );

    vio_engine #(.SCR_DEPTH(SCR_DEPTH)) u_eng (
        .clk(clk), .rst(rst), .io_sel(io_sel), .reg_off(reg_off),
        .ds_n(ds_n), .rw(rw), .iack(iack), .din(din),
        .dout(dout), .dout_en(dout_en), .dtack_n(dtack_n),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_empty(rx_empty)
    );

    vio_fifo #(.W(8), .DEPTH(FIFO_D)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_wdata),
        .pop(tx_pop), .rdata(tx_data), .empty(tx_empty), .full(tx_full)
    );

    vio_fifo #(.W(8), .DEPTH(FIFO_D)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_rdata), .empty(rx_empty), .full(rx_full)
    );

endmodule

// File: tb/vio_bus_slave_tb.sv
module vio_bus_slave_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] addr = '0;
    logic        ds_n = 1'b1, rw = 1'b1, iack = 1'b0, ext_map = 1'b1;
    logic [7:0]  din = '0;
    logic [7:0]  dout, tx_data, rx_byte = '0;
    logic        dout_en, dtack_n, tx_empty, rx_full;
    logic        tx_pop = 1'b0, rx_push = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    vio_bus_slave dut_i (
        .clk(clk), .rst(rst), .addr(addr), .ds_n(ds_n), .rw(rw), .iack(iack),
        .ext_map(ext_map), .din(din), .dout(dout), .dout_en(dout_en),
        .dtack_n(dtack_n), .tx_pop(tx_pop), .tx_data(tx_data),
        .tx_empty(tx_empty), .rx_push(rx_push), .rx_byte(rx_byte),
        .rx_full(rx_full)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One bus cycle; optional receive push lands on the service edge.
    task automatic bus(input logic [19:0] a, input logic rd, input logic [7:0] w,
                       output logic [7:0] r, output int lat,
                       input bit inj = 0, input logic [7:0] inj_v = 8'h00);
        @(negedge clk);
        addr = a; rw = rd; din = w; ds_n = 1'b0; lat = 0; r = 8'h00;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (inj && i == 1) begin rx_push = 1'b1; rx_byte = inj_v; end
            if (inj && i == 2) rx_push = 1'b0;
            if (!dtack_n) begin lat = i; r = dout; break; end
        end
        rx_push = 1'b0;
        ds_n = 1'b1;
        #1;
        check("R5 release", dtack_n, 1);
        @(negedge clk);
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] w, input string req);
        logic [7:0] r; int lat;
        bus(a, 1'b0, w, r, lat);
        check(req, lat, 3);
    endtask

    task automatic rd_chk(input logic [19:0] a, input logic [7:0] exp, input string req);
        logic [7:0] r; int lat;
        bus(a, 1'b1, 8'h00, r, lat);
        check(req, {lat, r}, {32'd3, exp});
    endtask

    task automatic no_resp(input logic [19:0] a, input logic rd, input string req);
        int bad = 0;
        @(negedge clk);
        addr = a; rw = rd; din = 8'h01; ds_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!dtack_n || dout_en) bad++;
        end
        ds_n = 1'b1;
        check(req, bad, 0);
        @(negedge clk);
    endtask

    task automatic rx_in(input logic [7:0] v);
        @(negedge clk); rx_push = 1'b1; rx_byte = v;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic t_reset;
        check("R5 reset dtack", dtack_n, 1);
        check("R3 reset oe", dout_en, 0);
        check("R8 reset tx empty", tx_empty, 1);
    endtask

    task automatic t_opcode;
        wr(20'hFFFFD, 8'h82, "R5 latency write");
        rd_chk(20'hFFFFD, 8'h82, "R6 opcode readback");
    endtask

    task automatic t_scratch;
        wr(20'hFFFFD, 8'h02, "R6 op write");
        wr(20'hFFFFC, 8'h11, "R10 w0"); wr(20'hFFFFC, 8'h22, "R10 w1");
        wr(20'hFFFFC, 8'h33, "R10 w2"); wr(20'hFFFFC, 8'h44, "R10 w3");
        wr(20'hFFFFC, 8'h55, "R10 wrap w");
        rd_chk(20'hFFFFC, 8'hFF, "R10 wrong direction");
        wr(20'hFFFFD, 8'h82, "R6 op write");
        rd_chk(20'hFFFFC, 8'h55, "R10 r0"); rd_chk(20'hFFFFC, 8'h22, "R10 r1");
        rd_chk(20'hFFFFC, 8'h33, "R10 r2"); rd_chk(20'hFFFFC, 8'h44, "R10 r3");
        rd_chk(20'hFFFFC, 8'h55, "R10 wrap r");
        rd_chk(20'hFFFFC, 8'h22, "R10 r1 again");
        wr(20'hFFFFD, 8'h82, "R6 op rewrite");
        rd_chk(20'hFFFFC, 8'h55, "R6 index reset");
    endtask

    task automatic t_windows;
        ext_map = 1'b1;
        wr(20'hFC001, 8'h82, "R1 mirror opcode");
        rd_chk(20'hFD5A0, 8'h55, "R1 mirror data");
        no_resp(20'hF8001, 1'b1, "R3 outside extended");
        no_resp(20'h80001, 1'b1, "R1 bit19 only not ext");
        ext_map = 1'b0;
        rd_chk(20'h80001, 8'h82, "R2 minimal window");
        no_resp(20'h7FFFD, 1'b1, "R3 outside minimal");
        ext_map = 1'b1;
    endtask

    task automatic t_reserved;
        wr(20'hFFFFE, 8'hAB, "R7 write");
        wr(20'hFFFFF, 8'hCD, "R7 write");
        rd_chk(20'hFFFFE, 8'hFF, "R7 read 10");
        rd_chk(20'hFFFFF, 8'hFF, "R7 read 11");
        rd_chk(20'hFFFFD, 8'h82, "R7 opcode kept");
        rd_chk(20'hFFFFC, 8'h22, "R7 index kept");
    endtask

    task automatic t_iack;
        iack = 1'b1;
        no_resp(20'hFFFFD, 1'b0, "R4 iack no ack");
        iack = 1'b0;
        rd_chk(20'hFFFFD, 8'h82, "R4 opcode unchanged");
    endtask

    task automatic t_tx;
        wr(20'hFFFFD, 8'h01, "R6 op write");
        for (int k = 0; k < 5; k++) wr(20'hFFFFC, 8'hA0 + 8'(k), "R8 tx write");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 tx order", {tx_empty, tx_data}, {1'b0, 8'hA0 + 8'(k)});
            tx_pop = 1'b1;
            @(negedge clk);
            tx_pop = 1'b0;
        end
        #1;
        check("R8 tx fifth dropped", tx_empty, 1);
    endtask

    task automatic t_rx;
        wr(20'hFFFFD, 8'h81, "R6 op write");
        rd_chk(20'hFFFFC, 8'hFF, "R9 empty read");
        rx_in(8'h31);
        rd_chk(20'hFFFFC, 8'h31, "R9 pop");
        rd_chk(20'hFFFFC, 8'hFF, "R9 empty after");
    endtask

    task automatic t_unknown;
        wr(20'hFFFFD, 8'h40, "R11 op write");
        wr(20'hFFFFC, 8'h99, "R11 write acked");
        rd_chk(20'hFFFFC, 8'hFF, "R11 read");
        check("R11 tx untouched", tx_empty, 1);
        wr(20'hFFFFD, 8'h82, "R6 op write");
        rd_chk(20'hFFFFC, 8'h55, "R11 scratch untouched");
    endtask

    task automatic t_collide;
        logic [7:0] r; int lat;
        wr(20'hFFFFD, 8'h81, "R6 op write");
        rx_in(8'h61); rx_in(8'h62);
        bus(20'hFFFFC, 1'b1, 8'h00, r, lat, 1'b1, 8'h63);
        check("R12 pop during push", {lat, r}, {32'd3, 8'h61});
        rd_chk(20'hFFFFC, 8'h62, "R12 order 2");
        rd_chk(20'hFFFFC, 8'h63, "R12 pushed kept");
        rd_chk(20'hFFFFC, 8'hFF, "R12 drained");
        for (int k = 1; k <= 4; k++) rx_in(8'h40 + 8'(k));
        check("R12 full", rx_full, 1);
        bus(20'hFFFFC, 1'b1, 8'h00, r, lat, 1'b1, 8'h45);
        check("R12 full pop during push", {lat, r}, {32'd3, 8'h41});
        for (int k = 2; k <= 5; k++) rd_chk(20'hFFFFC, 8'h40 + 8'(k), "R12 full order");
        rd_chk(20'hFFFFC, 8'hFF, "R12 full drained");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_opcode;
        t_scratch;
        t_windows;
        t_reserved;
        t_iack;
        t_tx;
        t_rx;
        t_unknown;
        t_collide;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule